// File: doc/BRIEF.md
# Multiplexed External Bus Sequencer

This block sits between a small microcontroller core and an 8-bit external bus on which the low address byte and the data share the same pins. The core raises a one-clock request carrying a 16-bit address, a direction, a data-memory select, a write byte and an extended-timing flag. The sequencer then runs one complete bus cycle and answers with a one-clock done pulse. On a read, the sampled byte is presented together with that pulse.

On the pad side, the high address byte goes out on its own port. The shared byte has an output value, an output enable and an input value. Four control lines frame each cycle: an active-low address strobe, an active-low data strobe, a read/write level and an active-low data-memory select.

A normal cycle takes six clocks: address setup, address strobe, turnaround, two clocks of data strobe, and recovery. Extended timing adds two clocks to the data-strobe phase, for eight clocks in total. Between cycles both strobes rest high and the shared pins are released.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset, as_n, ds_n, rw_n and dm_n are 1, ad_oe is 0 and rsp_done is 0.
- R2: In the setup clock and the single address-strobe clock, ad_oe is 1, ad_out carries address bits 7:0 and addr_hi carries address bits 15:8.
- R3: The two strobes are never low in the same clock. The clock after an address-strobe clock always has ds_n high, as a turnaround.
- R4: On a read (rw_n = 1), ad_oe is 0 from the turnaround clock through the recovery clock. rsp_rdata equals the byte on ad_in during the final data-strobe clock, and it is valid in the clock where rsp_done is 1.
- R5: On a write (rw_n = 0), ad_oe is 1 and ad_out equals the write byte from the turnaround clock through the recovery clock after ds_n rises.
- R6: ds_n is low for 2 consecutive clocks when req_ext is 0 and for 4 when req_ext is 1. rsp_done is 1 in the 6th or the 8th clock after the request is accepted.
- R7: rsp_done is high for exactly one clock per cycle.
- R8: rw_n (1 = read, 0 = write) and dm_n (0 = data memory selected) are valid from the setup clock, before the address strobe falls, and stay unchanged through the recovery clock.
- R9: When no cycle is in progress, as_n and ds_n are 1, ad_oe is 0, and rw_n and dm_n are 1.
- R10: A request raised while a cycle is in progress is ignored and starts no bus cycle.
- R11: as_n is low for exactly one clock per cycle. It falls again only after ds_n has risen and a recovery clock has passed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | One-clock request; accepted only when idle |
| req_addr | input | 16 | Cycle address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_dmem | input | 1 | 1 = data memory space |
| req_wdata | input | 8 | Write byte |
| req_ext | input | 1 | Extended timing: data strobe two clocks longer |
| rsp_done | output | 1 | One-clock end-of-cycle pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_done |
| addr_hi | output | 8 | High address byte pins |
| ad_out | output | 8 | Shared address/data pins, output value |
| ad_oe | output | 1 | Output enable of the shared pins |
| ad_in | input | 8 | Shared address/data pins, input value |
| as_n | output | 1 | Address strobe, active low |
| ds_n | output | 1 | Data strobe, active low |
| rw_n | output | 1 | Read/write level, 1 = read |
| dm_n | output | 1 | Data memory select, active low |

## Verification
Two events can fall in the same clock. The first is a new core request arriving while a cycle is still in progress. The bench provokes this by raising a differing request during the address-strobe clock. It then judges that the request was dropped: after done, the bus must stay idle with both strobes high and the pins released.

The second is the read sample colliding with the rise of the data strobe. The bench drives the correct byte on ad_in only while ds_n is low and drives its complement at every other time. A capture one clock late or one clock early therefore returns the wrong byte in the done clock.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SETUP,
        PH_ASTB,
        PH_TURN,
        PH_DSTB,
        PH_RECOV
    } phase_e;

endpackage

// File: rtl/mbs_phase_ctl.sv
module mbs_phase_ctl
    import mbs_pkg::*;
#(
    parameter int DS_CLKS  = 2,
    parameter int EXT_CLKS = 2
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   ext_q,
    output logic   accept,
    output logic   capture,
    output logic   done,
    output phase_e phase
);
    localparam int MAX_DS = DS_CLKS + EXT_CLKS;
    localparam int CNT_W  = $clog2(MAX_DS + 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } ctl_t;

    ctl_t s_d, s_q;

    assign accept  = req_valid && (s_q.phase == PH_IDLE);
    assign capture = (s_q.phase == PH_DSTB) && (s_q.cnt == '0);
    assign done    = s_q.done;
    assign phase   = s_q.phase;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.phase)
            PH_IDLE:  if (accept) s_d.phase = PH_SETUP;
            PH_SETUP: s_d.phase = PH_ASTB;
            PH_ASTB:  s_d.phase = PH_TURN;
            PH_TURN: begin
                s_d.phase = PH_DSTB;
                s_d.cnt   = ext_q ? CNT_W'(MAX_DS - 1) : CNT_W'(DS_CLKS - 1);
            end
            PH_DSTB: begin
                if (s_q.cnt == '0) begin
                    s_d.phase = PH_RECOV;
                    s_d.done  = 1'b1;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            PH_RECOV: s_d.phase = PH_IDLE;
            default:  s_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{phase: PH_IDLE, cnt: '0, done: 1'b0};
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/mbs_datapath.sv
module mbs_datapath
    import mbs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       accept,
    input  logic                       capture,
    input  phase_e                     phase,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic                       req_write,
    input  logic                       req_dmem,
    input  logic [DATA_W-1:0]          req_wdata,
    input  logic                       req_ext,
    input  logic [DATA_W-1:0]          ad_in,
    output logic                       ext_q,
    output logic [DATA_W-1:0]          rdata,
    output logic [ADDR_W-DATA_W-1:0]   addr_hi,
    output logic [DATA_W-1:0]          ad_out,
    output logic                       ad_oe,
    output logic                       as_n,
    output logic                       ds_n,
    output logic                       rw_n,
    output logic                       dm_n
);
    localparam int HI_W = ADDR_W - DATA_W;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              dmem;
        logic              ext;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } dp_t;

    dp_t r_d, r_q;

    logic addr_phase;
    logic data_phase;
    logic active;

    assign active     = (phase != PH_IDLE);
    assign addr_phase = (phase == PH_SETUP) || (phase == PH_ASTB);
    assign data_phase = (phase == PH_TURN) || (phase == PH_DSTB) || (phase == PH_RECOV);

    always_comb begin
        r_d = r_q;
        if (accept) begin
            r_d.addr  = req_addr;
            r_d.write = req_write;
            r_d.dmem  = req_dmem;
            r_d.ext   = req_ext;
            r_d.wdata = req_wdata;
        end
        if (capture && !r_q.write) begin
            r_d.rdata = ad_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ext_q   = r_q.ext;
    assign rdata   = r_q.rdata;
    assign addr_hi = r_q.addr[ADDR_W-1 -: HI_W];
    assign ad_out  = addr_phase ? r_q.addr[DATA_W-1:0] : r_q.wdata;
    assign ad_oe   = addr_phase || (data_phase && r_q.write);
    assign as_n    = (phase != PH_ASTB);
    assign ds_n    = (phase != PH_DSTB);
    assign rw_n    = active ? !r_q.write : 1'b1;
    assign dm_n    = active ? !r_q.dmem : 1'b1;

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq
    import mbs_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int DS_CLKS  = 2,
    parameter int EXT_CLKS = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_write,
    input  logic                     req_dmem,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic                     req_ext,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic [ADDR_W-DATA_W-1:0] addr_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    input  logic [DATA_W-1:0]        ad_in,
    output logic                     as_n,
    output logic                     ds_n,
    output logic                     rw_n,
    output logic                     dm_n
);
    logic   accept;
    logic   capture;
    logic   ext_q;
    phase_e phase;

    mbs_phase_ctl #(
        .DS_CLKS  (DS_CLKS),
        .EXT_CLKS (EXT_CLKS)
    ) i_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .ext_q     (ext_q),
        .accept    (accept),
        .capture   (capture),
        .done      (rsp_done),
        .phase     (phase)
    );

    mbs_datapath #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) i_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .capture   (capture),
        .phase     (phase),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_dmem  (req_dmem),
        .req_wdata (req_wdata),
        .req_ext   (req_ext),
        .ad_in     (ad_in),
        .ext_q     (ext_q),
        .rdata     (rsp_rdata),
        .addr_hi   (addr_hi),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe),
        .as_n      (as_n),
        .ds_n      (ds_n),
        .rw_n      (rw_n),
        .dm_n      (dm_n)
    );

endmodule

// File: rtl/mbs_checker.sv
module mbs_checker (
    input logic clk,
    input logic rst_n,
    input logic as_n,
    input logic ds_n,
    input logic rw_n,
    input logic dm_n,
    input logic ad_oe,
    input logic rsp_done
);
    a_r3_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(!as_n && !ds_n));

    a_r3_turnaround: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> ds_n);

    a_r11_as_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |=> as_n);

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);

    a_r2_addr_driven: assert property (@(posedge clk) disable iff (!rst_n)
        !as_n |-> ad_oe);

    a_r4_read_released: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && rw_n) |-> !ad_oe);

    a_r5_write_driven: assert property (@(posedge clk) disable iff (!rst_n)
        (!ds_n && !rw_n) |-> ad_oe);

    a_r8_rw_held: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ds_n) |-> ($stable(rw_n) && $stable(dm_n)));

endmodule

bind mux_bus_seq mbs_checker i_mbs_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .as_n     (as_n),
    .ds_n     (ds_n),
    .rw_n     (rw_n),
    .dm_n     (dm_n),
    .ad_oe    (ad_oe),
    .rsp_done (rsp_done)
);

// File: tb/test_mux_bus_seq.sv
module test_mux_bus_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_dmem = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic        req_ext = 1'b0;
    logic        rsp_done;
    logic [7:0]  rsp_rdata;
    logic [7:0]  addr_hi;
    logic [7:0]  ad_out;
    logic        ad_oe;
    logic [7:0]  ad_in = '0;
    logic        as_n, ds_n, rw_n, dm_n;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    mux_bus_seq i_mux_bus_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .req_dmem(req_dmem), .req_wdata(req_wdata),
        .req_ext(req_ext), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .as_n(as_n), .ds_n(ds_n), .rw_n(rw_n), .dm_n(dm_n)
    );

    function automatic logic [7:0] dev_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    task automatic check(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_run();
        end
    end

    task automatic check_idle(input string req);
        check(as_n && ds_n, req, {as_n, ds_n}, 2'b11);
        check(!ad_oe, req, ad_oe, 0);
        check(rw_n && dm_n, req, {rw_n, dm_n}, 2'b11);
    endtask

    task automatic run_txn(input logic [15:0] a, input logic wr, input logic dm,
                           input logic [7:0] wd, input logic ext, input logic poke);
        int ds_low = 0;
        int n_done = 0;
        logic [7:0] good = dev_byte(a);
        @(negedge clk);
        req_addr = a; req_write = wr; req_dmem = dm; req_wdata = wd; req_ext = ext;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        for (int n = 1; n <= 12; n++) begin
            if (n > 1) @(negedge clk);
            ad_in = ds_n ? ~good : good;
            if (n == 2 && poke) begin
                req_addr = ~a; req_write = ~wr; req_ext = ~ext; req_valid = 1'b1;
            end
            if (n == 3) req_valid = 1'b0;
            check(!(!as_n && !ds_n), "R3 both strobes low", {as_n, ds_n}, 2'b11);
            if (n == 1) begin
                check(as_n && ds_n, "R11 setup strobes", {as_n, ds_n}, 2'b11);
                check(ad_oe && ad_out == a[7:0], "R2 setup addr lo", ad_out, a[7:0]);
                check(addr_hi == a[15:8], "R2 setup addr hi", addr_hi, a[15:8]);
                check(rw_n == !wr && dm_n == !dm, "R8 lines before AS", {rw_n, dm_n}, {!wr, !dm});
            end
            if (n == 2) begin
                check(!as_n && ds_n, "R11 address strobe", {as_n, ds_n}, 2'b01);
                check(ad_oe && ad_out == a[7:0], "R2 strobe addr lo", ad_out, a[7:0]);
                check(addr_hi == a[15:8], "R2 strobe addr hi", addr_hi, a[15:8]);
            end
            if (n == 3) begin
                check(as_n && ds_n, "R3 turnaround", {as_n, ds_n}, 2'b11);
                check(ad_oe == wr, "R4 R5 turnaround drive", ad_oe, wr);
            end
            if (n >= 3) check(as_n, "R11 single AS", as_n, 1);
            if (!ds_n) begin
                ds_low++;
                if (wr) check(ad_oe && ad_out == wd, "R5 write data", ad_out, wd);
                else    check(!ad_oe, "R4 read released", ad_oe, 0);
                check(rw_n == !wr && dm_n == !dm, "R8 lines in DS", {rw_n, dm_n}, {!wr, !dm});
            end
            if (rsp_done) begin
                n_done = n;
                break;
            end
        end
        check(n_done == (ext ? 8 : 6), "R6 done clock", n_done, ext ? 8 : 6);
        check(ds_low == (ext ? 4 : 2), "R6 DS width", ds_low, ext ? 4 : 2);
        check(ds_n, "R11 recovery DS high", ds_n, 1);
        check(rw_n == !wr && dm_n == !dm, "R8 held in recovery", {rw_n, dm_n}, {!wr, !dm});
        if (wr) check(ad_oe && ad_out == wd, "R5 write hold", ad_out, wd);
        else begin
            check(!ad_oe, "R4 recovery released", ad_oe, 0);
            check(rsp_rdata == good, "R4 read data", rsp_rdata, good);
        end
        @(negedge clk);
        check(!rsp_done, "R7 done width", rsp_done, 0);
        check_idle("R9 idle after cycle");
        @(negedge clk);
        check_idle(poke ? "R10 busy request ignored" : "R9 idle");
    endtask

    initial begin
        void'($urandom(32'd20240607));
        #1;
        check(as_n && ds_n && rw_n && dm_n, "R1 reset lines", {as_n, ds_n, rw_n, dm_n}, 4'hF);
        check(!ad_oe && !rsp_done, "R1 reset oe/done", {ad_oe, rsp_done}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R9 idle after reset");
        run_txn(16'h0000, 1'b0, 1'b0, 8'h00, 1'b0, 1'b0);
        run_txn(16'hFFFF, 1'b1, 1'b1, 8'hA5, 1'b0, 1'b0);
        run_txn(16'h1234, 1'b0, 1'b1, 8'h00, 1'b1, 1'b0);
        run_txn(16'hBEEF, 1'b1, 1'b0, 8'h3C, 1'b1, 1'b0);
        run_txn(16'h8001, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1);
        run_txn(16'h4002, 1'b1, 1'b1, 8'h77, 1'b1, 1'b1);
        for (int i = 0; i < 60; i++) begin
            run_txn(16'($urandom), 1'($urandom), 1'($urandom), 8'($urandom),
                    1'($urandom), 1'($urandom_range(0, 3) == 0));
        end
        finish_run();
    end

endmodule